// File: doc/BRIEF.md
# Power-Management Sleep Control Register

This block holds a 16-bit power-management control word behind a small port-mapped interface. Software can write the low byte, the high byte or the whole word, and can read back either byte or the whole word. The register also serves as the sleep trigger: it turns a correctly formed sleep request into single-cycle request pulses that the surrounding chip logic acts on.

A sleep request is taken from the value as written, not from the stored value. The sleep-enable bit is never kept in storage, so one write makes at most one request. Only a high-byte write or a word write can make a request. The encoded sleep type decides the action. A suspend-to-RAM request asks for a system reset and flags that the next boot is a resume. A hibernate request or a soft-off request asks for a shutdown.

Top module: `pwr_ctl_reg`

## Requirements
- R1: After reset the stored word is 0x0001, with only the SCI-enable bit (bit 0) set. All request pulses are low and the sleep-state status output is 0.
- R2: A byte write at offset 4 replaces bits 7:0 with wdata_i[7:0]. Bits 15:8 keep their value, and no request pulse follows.
- R3: A byte write at offset 5 replaces bits 15:8 with wdata_i[7:0]. A word write at offset 4 replaces all 16 bits. In both cases the stored sleep-enable bit (bit 13) is forced to 0.
- R4: A request is made only when the written sleep-enable bit is 1. For a word write this is wdata_i[13]. For a high-byte write it is wdata_i[5]. The 3-bit sleep type is written value bits 12:10, which is wdata_i[4:2] for a high-byte write.
- R5: Sleep type 5 raises sys_reset_req_o and resume_flag_o together for exactly one cycle, in the cycle after the write edge. From that edge on, sstate_o reads 3 and keeps that value.
- R6: Sleep types 6 and 7 raise shutdown_req_o for exactly one cycle, in the cycle after the write edge. Sleep types 0 to 4 produce no request.
- R7: Reads are combinational and force bit 2 (global-lock release) and bit 13 (sleep-enable) to 0. A byte read at offset 4 returns bits 7:0 in rdata_o[7:0]. A byte read at offset 5 returns bits 15:8 in rdata_o[7:0]. A word read at offset 4 returns all 16 bits. The unused upper bits of a byte read are 0.
- R8: A write to any other offset, or a word write at offset 5, changes nothing and makes no request. A read of such an access returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | ADDR_W | Port offset of the access |
| word_i | input | 1 | 1: 16-bit access, 0: byte access |
| wdata_i | input | 16 | Write data; byte writes use bits 7:0 |
| rdata_o | output | 16 | Read data for the addressed access, masked |
| sys_reset_req_o | output | 1 | One-cycle system reset request (suspend-to-RAM) |
| resume_flag_o | output | 1 | One-cycle flag marking a resume from suspend |
| shutdown_req_o | output | 1 | One-cycle shutdown request (hibernate or soft-off) |
| sstate_o | output | 3 | Last sleep state entered through the reset path (0 or 3) |

## Verification
Read data is combinational, so the bench sets the address and checks rdata_o a moment later in the same low clock phase. A stored write shows up on the next read after the write edge. The request pulses and sstate_o are registered, so the bench checks them at the falling edge right after the write's rising edge. It then waits one more falling edge and checks that each pulse has dropped, which shows it lasted one cycle. Expected values come from a reference model in the bench. The model is driven by directed cases for every sleep type, both request paths, the masked bits and off-map offsets, and by seeded random accesses.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int unsigned CTL_W      = 16;
  localparam int unsigned SCI_EN_BIT = 0;
  localparam int unsigned GLR_BIT    = 2;
  localparam int unsigned SE_BIT     = 13;
  localparam int unsigned TYP_LSB    = 10;
  localparam int unsigned TYP_W      = 3;
  localparam int unsigned SST_W      = 3;

  localparam logic [CTL_W-1:0] RST_VAL = CTL_W'(1) << SCI_EN_BIT;
  localparam logic [CTL_W-1:0] SE_MASK = CTL_W'(1) << SE_BIT;
  localparam logic [CTL_W-1:0] RD_MASK = ~((CTL_W'(1) << GLR_BIT) | SE_MASK);

  typedef enum logic [1:0] {ACC_NONE, ACC_LO, ACC_HI, ACC_WORD} acc_e;

  typedef enum logic [TYP_W-1:0] {
    SLP_RAM  = 3'd5,
    SLP_HIB  = 3'd6,
    SLP_OFF  = 3'd7
  } slp_typ_e;

  localparam logic [SST_W-1:0] SST_RAM = 3'd3;
endpackage

// File: rtl/pwr_ctl_decode.sv
module pwr_ctl_decode
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned REG_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  output acc_e              acc_o
);
  localparam logic [ADDR_W-1:0] OFS_LO = ADDR_W'(REG_OFS);
  localparam logic [ADDR_W-1:0] OFS_HI = ADDR_W'(REG_OFS + 1);

  always_comb begin
    acc_o = ACC_NONE;
    if (word_i) begin
      if (addr_i == OFS_LO) acc_o = ACC_WORD;
    end else if (addr_i == OFS_LO) begin
      acc_o = ACC_LO;
    end else if (addr_i == OFS_HI) begin
      acc_o = ACC_HI;
    end
  end
endmodule

// File: rtl/pwr_ctl_store.sv
module pwr_ctl_store
  import pwr_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  acc_e             acc_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             req_vld_o,
  output logic [CTL_W-1:0] req_val_o
);
  localparam int unsigned BYTE_W = CTL_W / 2;

  logic [CTL_W-1:0] ctl_q, ctl_d;

  // value as written, aligned to register bit positions
  always_comb begin
    req_val_o = '0;
    req_vld_o = 1'b0;
    ctl_d     = ctl_q;
    if (wr_i) begin
      unique case (acc_i)
        ACC_LO:   ctl_d = {ctl_q[CTL_W-1:BYTE_W], wdata_i[BYTE_W-1:0]};
        ACC_HI: begin
          req_val_o = {wdata_i[BYTE_W-1:0], ctl_q[BYTE_W-1:0]};
          req_vld_o = 1'b1;
          ctl_d     = req_val_o & ~SE_MASK;
        end
        ACC_WORD: begin
          req_val_o = wdata_i;
          req_vld_o = 1'b1;
          ctl_d     = wdata_i & ~SE_MASK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= RST_VAL;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/pwr_ctl_sleep.sv
module pwr_ctl_sleep
  import pwr_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_vld_i,
  input  logic             req_se_i,
  input  logic [TYP_W-1:0] req_typ_i,
  output logic             sys_reset_req_o,
  output logic             resume_flag_o,
  output logic             shutdown_req_o,
  output logic [SST_W-1:0] sstate_o
);
  logic ram_hit, off_hit;
  logic rst_q, res_q, off_q;
  logic [SST_W-1:0] sst_q;

  always_comb begin
    ram_hit = 1'b0;
    off_hit = 1'b0;
    if (req_vld_i && req_se_i) begin
      unique case (req_typ_i)
        SLP_RAM:          ram_hit = 1'b1;
        SLP_HIB, SLP_OFF: off_hit = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      res_q <= 1'b0;
      off_q <= 1'b0;
      sst_q <= '0;
    end else begin
      rst_q <= ram_hit;
      res_q <= ram_hit;
      off_q <= off_hit;
      if (ram_hit) sst_q <= SST_RAM;
    end
  end

  assign sys_reset_req_o = rst_q;
  assign resume_flag_o   = res_q;
  assign shutdown_req_o  = off_q;
  assign sstate_o        = sst_q;
endmodule

// File: rtl/pwr_ctl_rdmux.sv
module pwr_ctl_rdmux
  import pwr_ctl_pkg::*;
(
  input  acc_e             acc_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic [CTL_W-1:0] rdata_o
);
  localparam int unsigned BYTE_W = CTL_W / 2;

  logic [CTL_W-1:0] vis;

  assign vis = ctl_i & RD_MASK;

  always_comb begin
    unique case (acc_i)
      ACC_LO:   rdata_o = {{BYTE_W{1'b0}}, vis[BYTE_W-1:0]};
      ACC_HI:   rdata_o = {{BYTE_W{1'b0}}, vis[CTL_W-1:BYTE_W]};
      ACC_WORD: rdata_o = vis;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned REG_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              sys_reset_req_o,
  output logic              resume_flag_o,
  output logic              shutdown_req_o,
  output logic [2:0]        sstate_o
);
  acc_e             acc;
  logic [CTL_W-1:0] ctl_q;
  logic             req_vld;
  logic [CTL_W-1:0] req_val;

  pwr_ctl_decode #(
    .ADDR_W (ADDR_W),
    .REG_OFS(REG_OFS)
  ) u_decode (
    .addr_i(addr_i),
    .word_i(word_i),
    .acc_o (acc)
  );

  pwr_ctl_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .acc_i    (acc),
    .wdata_i  (wdata_i),
    .ctl_o    (ctl_q),
    .req_vld_o(req_vld),
    .req_val_o(req_val)
  );

  pwr_ctl_sleep u_sleep (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_vld_i      (req_vld),
    .req_se_i       (req_val[SE_BIT]),
    .req_typ_i      (req_val[TYP_LSB +: TYP_W]),
    .sys_reset_req_o(sys_reset_req_o),
    .resume_flag_o  (resume_flag_o),
    .shutdown_req_o (shutdown_req_o),
    .sstate_o       (sstate_o)
  );

  pwr_ctl_rdmux u_rdmux (
    .acc_i  (acc),
    .ctl_i  (ctl_q),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned REG_OFS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              word_i,
  input logic              wdata_se_i,
  input logic [15:8]       ctl_hi_i,
  input logic              ctl_se_i,
  input logic              rd_glr_i,
  input logic              rd_se_i,
  input logic              sys_reset_req_i,
  input logic              resume_flag_i,
  input logic              shutdown_req_i,
  input logic [2:0]        sstate_i
);
  logic lo_wr, word_acc;
  assign lo_wr    = wr_i && !word_i && (addr_i == ADDR_W'(REG_OFS));
  assign word_acc = word_i && (addr_i == ADDR_W'(REG_OFS));

  AST_SE_NEVER_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_se_i); // R3
  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr |=> ctl_hi_i == $past(ctl_hi_i)); // R2
  AST_LO_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr |=> !sys_reset_req_i && !shutdown_req_i); // R2
  AST_NO_SE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_acc && !wdata_se_i) |=> !sys_reset_req_i && !shutdown_req_i); // R4
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_i |=> !sys_reset_req_i); // R5
  AST_RESUME_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_i == resume_flag_i); // R5
  AST_RAM_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_i |-> sstate_i == 3'd3); // R5
  AST_OFF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_req_i |=> !shutdown_req_i); // R6
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shutdown_req_i && sys_reset_req_i)); // R6
  AST_RD_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_acc |-> !rd_glr_i && !rd_se_i); // R7
endmodule

bind pwr_ctl_reg pwr_ctl_chk #(
  .ADDR_W (ADDR_W),
  .REG_OFS(REG_OFS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_i           (wr_i),
  .addr_i         (addr_i),
  .word_i         (word_i),
  .wdata_se_i     (wdata_i[13]),
  .ctl_hi_i       (ctl_q[15:8]),
  .ctl_se_i       (ctl_q[13]),
  .rd_glr_i       (rdata_o[2]),
  .rd_se_i        (rdata_o[13]),
  .sys_reset_req_i(sys_reset_req_o),
  .resume_flag_i  (resume_flag_o),
  .shutdown_req_i (shutdown_req_o),
  .sstate_i       (sstate_o)
);

// File: tb/pwr_ctl_reg_tb.sv
`timescale 1ns/100ps
module pwr_ctl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic        word = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req, resume, shut;
  logic [2:0]  sst;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_ctl = 16'h0001;
  logic [2:0]  m_sst = 3'd0;

  always #2.5 clk = ~clk;

  pwr_ctl_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .word_i(word),
    .wdata_i(wdata), .rdata_o(rdata), .sys_reset_req_o(rst_req),
    .resume_flag_o(resume), .shutdown_req_o(shut), .sstate_o(sst)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [7:0] a, input logic w);
    logic [15:0] v;
    v = m_ctl & 16'hDFFB;
    if (w) return (a == 8'd4) ? v : 16'h0;
    if (a == 8'd4) return {8'h0, v[7:0]};
    if (a == 8'd5) return {8'h0, v[15:8]};
    return 16'h0;
  endfunction

  task automatic rd(input logic [7:0] a, input logic w, input string req);
    @(negedge clk);
    addr = a; word = w; wr = 1'b0;
    #1;
    chk(rdata == exp_rd(a, w), req, "read", rdata, exp_rd(a, w));
  endtask

  // one write, then checks of pulses (next cycle) and their drop (cycle after)
  task automatic wr_acc(input logic [7:0] a, input logic w, input logic [15:0] d,
                        input string req);
    bit vld, se, e_ram, e_off;
    logic [2:0] typ;
    logic [15:0] val;
    vld = 1'b0; val = '0;
    if (w && a == 8'd4) begin
      vld = 1'b1; val = d;
    end else if (!w && a == 8'd4) begin
      m_ctl = {m_ctl[15:8], d[7:0]};
    end else if (!w && a == 8'd5) begin
      vld = 1'b1; val = {d[7:0], m_ctl[7:0]};
    end
    if (vld) m_ctl = val & 16'hDFFF;
    se = val[13]; typ = val[12:10];
    e_ram = vld && se && typ == 3'd5;
    e_off = vld && se && (typ == 3'd6 || typ == 3'd7);
    if (e_ram) m_sst = 3'd3;
    @(negedge clk);
    addr = a; word = w; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk(rst_req == e_ram, req, "reset pulse", 16'(rst_req), 16'(e_ram));
    chk(resume == e_ram, req, "resume pulse", 16'(resume), 16'(e_ram));
    chk(shut == e_off, req, "shutdown pulse", 16'(shut), 16'(e_off));
    chk(sst == m_sst, req, "sstate", 16'(sst), 16'(m_sst));
    @(negedge clk);
    chk(!rst_req && !resume && !shut, req, "pulse drop",
        {13'h0, rst_req, resume, shut}, 16'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 0x%04h expected 0x%04h", 16'h1, 16'h0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0421));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rst_req == 0 && resume == 0 && shut == 0, "R1", "pulses at reset",
        {13'h0, rst_req, resume, shut}, 16'h0);
    chk(sst == 3'd0, "R1", "sstate at reset", 16'(sst), 16'h0);
    rst_n = 1'b1;
    rd(8'd4, 1'b1, "R1");
    // R2 low byte keeps high, no request even with SE-looking data
    wr_acc(8'd5, 1'b0, 16'h00C3, "R3");
    wr_acc(8'd4, 1'b0, 16'h00FF, "R2");
    rd(8'd4, 1'b1, "R2");
    rd(8'd5, 1'b0, "R2");
    // R3 SE never stored; R7 masking
    wr_acc(8'd4, 1'b1, 16'hFFFF, "R3");
    rd(8'd4, 1'b1, "R7");
    rd(8'd4, 1'b0, "R7");
    rd(8'd5, 1'b0, "R7");
    // R4 no request without SE, any type
    for (int t = 0; t < 8; t++) wr_acc(8'd4, 1'b1, 16'(t << 10), "R4");
    // R6 types 0..4 ignored, 6/7 shutdown, through both paths
    for (int t = 0; t < 8; t++) begin
      if (t != 5) begin
        wr_acc(8'd4, 1'b1, 16'h2000 | 16'(t << 10), "R6");
        wr_acc(8'd5, 1'b0, 16'h0020 | 16'(t << 2), "R6");
      end
    end
    chk(sst == 3'd0, "R6", "sstate untouched", 16'(sst), 16'h0);
    // R5 suspend via high byte then word
    wr_acc(8'd5, 1'b0, 16'h0034, "R5");
    rd(8'd4, 1'b1, "R5");
    wr_acc(8'd4, 1'b1, 16'h3401, "R5");
    wr_acc(8'd4, 1'b1, 16'h0000, "R5");
    // R8 off-map and word at 5
    wr_acc(8'd5, 1'b1, 16'h3C00, "R8");
    wr_acc(8'd6, 1'b0, 16'h00FF, "R8");
    wr_acc(8'd3, 1'b1, 16'hBC00, "R8");
    rd(8'd4, 1'b1, "R8");
    rd(8'd5, 1'b1, "R8");
    rd(8'd7, 1'b0, "R8");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic w;
      logic [15:0] d;
      a = 8'd3 + 8'($urandom_range(0, 3));
      w = 1'($urandom);
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 0) d = d | (w ? 16'h2000 : 16'h0020);
      wr_acc(a, w, d, "R4");
      rd(8'd3 + 8'($urandom_range(0, 3)), 1'($urandom), "R7");
    end
    finish_run();
  end
endmodule